// File: doc/BRIEF.md
# Serial DAC Host Write Controller

This block sits on the host side of a four-channel, 12-bit serial digital-to-analog converter with double-buffered channel registers. It takes one command at a time over a valid/ready handshake and turns it into a correctly timed pin sequence. A write command shifts one 16-bit word into the converter and then strobes it into the channel register selected by the word. An update command pulses the commit strobe so that all four outputs change together, then optionally holds off the next command for the analog settling time. A clear command sets the clear-level pin and pulses the converter's clear input.

Each minimum timing figure is a nanosecond parameter. It is turned into a count of system clock cycles by rounding up. The serial clock idles high, so the select line is only ever released while the serial clock is high. The latch strobe is kept off until the frame has ended and the select line has risen. All pins come from registers, so they cannot glitch.

Top module: `serdac_writer`

## Requirements
- R1: A write shifts exactly 16 bits while the select line is low, one on each rising serial clock edge. The order is channel bit 1, channel bit 0, two zero bits, then code bit 11 down to code bit 0.
- R2: The serial clock idles high. Each low phase lasts at least max(ceil(50/T), ceil(25/T)) cycles, and each in-frame high phase lasts at least ceil(30/T) cycles, where T is the system clock period in ns. Serial data changes inside a frame only on a falling serial clock edge.
- R3: The select line falls at least ceil(55/T) cycles before the first rising edge. It rises only while the serial clock is high, at least ceil(15/T) cycles after the last rising edge.
- R4: After each frame the latch strobe goes low for exactly ceil(45/T) cycles. It goes low only while the select line is high, and no sooner than ceil(15/T) cycles after the last rising edge. The channel register named by bits 15:14 of the frame takes the code.
- R5: An update drives the commit strobe low for exactly ceil(45/T) cycles, and all four outputs take their channel registers together.
- R6: After an update, ready stays low for exactly ceil(45/T) + ceil(SETTLE_NS/T) cycles when the settling wait is enabled (10 µs by default).
- R7: A clear drives the clear-level pin to the command's level at least ceil(25/T) cycles before the clear strobe falls. The strobe then stays low for exactly ceil(70/T) cycles. Every register goes to 0x800 if the level is 1 and to 0x000 if it is 0.
- R8: A command is taken at a clock edge where valid and ready are both high. Opcodes: 0 write, 1 update, 2 clear, 3 no-op. After a write, ready stays low for exactly ceil(55/T) + 16·(low + high phase) + ceil(45/T) + ceil(40/T) cycles. After a clear it stays low for exactly ceil(25/T) + ceil(70/T) cycles.
- R9: Opcode 3 is taken with no effect: ready stays high, every pin keeps its idle level, and no converter register changes.
- R10: After reset, ready is high and the serial clock, select, latch, commit and clear strobes are all high.
- R11: Writes without an update change the channel registers but leave all four outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Controller idle and able to take a command |
| cmd_op | input | 2 | Opcode: 0 write, 1 update, 2 clear, 3 no-op |
| cmd_chan | input | 2 | Channel for a write |
| cmd_code | input | 12 | Code for a write |
| cmd_level | input | 1 | Clear level: 1 mid-scale, 0 zero-scale |
| dac_sclk | output | 1 | Serial clock, idles high |
| dac_sel_n | output | 1 | Active-low select |
| dac_mosi | output | 1 | Serial data, MSB first |
| dac_latch_n | output | 1 | Active-low channel register latch strobe |
| dac_commit_n | output | 1 | Active-low strobe moving all channels to outputs |
| dac_clear_n | output | 1 | Active-low clear strobe |
| dac_clear_mid | output | 1 | Clear level pin |

## Verification
The handshake point is the reference for each command. Its first effect shows up on the pins in the first cycle after the accepting edge. Ready comes back exactly the R8 or R6 busy count later, and the bench counts cycles of low ready on falling-edge samples and compares them with that total. Inside a command, each pulse length, each setup window and each pin level at a rising or falling serial clock edge is measured on the same falling-edge samples, counting whole cycles between the observed pin transitions. A behavioural model of the converter, driven only by the pins, is compared with the expected channel and output registers one cycle after ready returns.

// File: rtl/serdac_pkg.sv
`timescale 1ns/1ps
package serdac_pkg;

    localparam int FRAME_W = 16;
    localparam int CODE_W  = 12;
    localparam int CH_W    = 2;
    localparam int PAD_W   = FRAME_W - CH_W - CODE_W;
    localparam int BIT_W   = $clog2(FRAME_W);

    typedef enum logic [1:0] {
        OP_WRITE  = 2'd0,
        OP_UPDATE = 2'd1,
        OP_CLEAR  = 2'd2,
        OP_NOP    = 2'd3
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [CH_W-1:0]   chan;
        logic [CODE_W-1:0] code;
        logic              level;
    } cmd_t;

    typedef enum logic [3:0] {
        S_IDLE, S_SEL_SETUP, S_CLK_LO, S_CLK_HI, S_LATCH, S_LATCH_REC,
        S_COMMIT, S_SETTLE, S_LEVEL_SETUP, S_CLEAR
    } state_e;

    typedef struct packed {
        logic sclk;
        logic sel_n;
        logic latch_n;
        logic commit_n;
        logic clear_n;
    } pins_t;

    localparam pins_t PINS_IDLE = '{sclk: 1'b1, sel_n: 1'b1, latch_n: 1'b1,
                                    commit_n: 1'b1, clear_n: 1'b1};

    // Cycles needed to cover a minimum time, never less than one.
    function automatic int ns2cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [FRAME_W-1:0] build_frame(input cmd_t c);
        return {c.chan, {PAD_W{1'b0}}, c.code};
    endfunction

endpackage

// File: rtl/serdac_timer.sv
`timescale 1ns/1ps
module serdac_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                 cnt_q <= '0;
        else if (load)           cnt_q <= load_val;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

    a_r8_timer_counts_down: assert property (@(posedge clk) disable iff (rst)
        (!load && !expired) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/serdac_shifter.sv
`timescale 1ns/1ps
module serdac_shifter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         shift,
    output logic         msb
);
    logic [W-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst)        sr_q <= '0;
        else if (load)  sr_q <= din;
        else if (shift) sr_q <= {sr_q[W-2:0], 1'b0};
    end

    assign msb = sr_q[W-1];

    a_r1_load_presents_msb: assert property (@(posedge clk) disable iff (rst)
        load |=> (msb == $past(din[W-1])));
endmodule

// File: rtl/serdac_writer.sv
`timescale 1ns/1ps
module serdac_writer
    import serdac_pkg::*;
#(
    parameter int CLK_NS      = 20,
    parameter int T_DS_NS     = 25,
    parameter int T_DH_NS     = 20,
    parameter int T_CH_NS     = 30,
    parameter int T_CL_NS     = 50,
    parameter int T_CSS_NS    = 55,
    parameter int T_CSH_NS    = 15,
    parameter int T_LD1_NS    = 40,
    parameter int T_LD2_NS    = 15,
    parameter int T_LDRW_NS   = 45,
    parameter int T_LDDW_NS   = 45,
    parameter int T_RSTW_NS   = 70,
    parameter int T_RSSH_NS   = 25,
    parameter int SETTLE_NS   = 10000,
    parameter bit SETTLE_EN   = 1'b1,
    parameter bit LEVEL_INIT  = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_op,
    input  logic [1:0]        cmd_chan,
    input  logic [11:0]       cmd_code,
    input  logic              cmd_level,
    output logic              dac_sclk,
    output logic              dac_sel_n,
    output logic              dac_mosi,
    output logic              dac_latch_n,
    output logic              dac_commit_n,
    output logic              dac_clear_n,
    output logic              dac_clear_mid
);
    // Phase lengths in cycles; each merges every constraint that bounds it.
    localparam int LO_C     = imax(ns2cyc(T_CL_NS, CLK_NS), ns2cyc(T_DS_NS, CLK_NS));
    localparam int HI_C     = imax(imax(ns2cyc(T_CH_NS, CLK_NS), ns2cyc(T_DH_NS, CLK_NS)),
                                   imax(ns2cyc(T_CSH_NS, CLK_NS), ns2cyc(T_LD2_NS, CLK_NS)));
    localparam int SSU_C    = ns2cyc(T_CSS_NS, CLK_NS);
    localparam int LAT_C    = ns2cyc(T_LDRW_NS, CLK_NS);
    localparam int LREC_C   = ns2cyc(T_LD1_NS, CLK_NS);
    localparam int COM_C    = ns2cyc(T_LDDW_NS, CLK_NS);
    localparam int CLR_C    = ns2cyc(T_RSTW_NS, CLK_NS);
    localparam int LSU_C    = ns2cyc(T_RSSH_NS, CLK_NS);
    localparam int SET_C    = ns2cyc(SETTLE_NS, CLK_NS);
    localparam int MAX_C    = imax(imax(imax(LO_C, HI_C), imax(SSU_C, LAT_C)),
                                   imax(imax(LREC_C, COM_C), imax(imax(CLR_C, LSU_C), SET_C)));
    localparam int TW       = $clog2(MAX_C + 1);

    cmd_t               cmd;
    state_e             st_q, st_d;
    pins_t              pins_q, pins_d;
    logic               level_q, level_d;
    logic [BIT_W-1:0]   bit_q, bit_d;
    logic               tmr_load, tmr_done;
    logic [TW-1:0]      tmr_val;
    logic               sh_load, sh_shift, mosi;

    assign cmd = '{op: op_e'(cmd_op), chan: cmd_chan, code: cmd_code, level: cmd_level};

    serdac_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    serdac_shifter #(.W(FRAME_W)) u_shift (
        .clk   (clk),
        .rst   (rst),
        .load  (sh_load),
        .din   (build_frame(cmd)),
        .shift (sh_shift),
        .msb   (mosi)
    );

    always_comb begin
        st_d     = st_q;
        pins_d   = pins_q;
        level_d  = level_q;
        bit_d    = bit_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        unique case (st_q)
            S_IDLE: if (cmd_valid) begin
                unique case (cmd.op)
                    OP_WRITE: begin
                        st_d         = S_SEL_SETUP;
                        pins_d.sel_n = 1'b0;
                        sh_load      = 1'b1;
                        bit_d        = '0;
                        tmr_load     = 1'b1;
                        tmr_val      = TW'(SSU_C - 1);
                    end
                    OP_UPDATE: begin
                        st_d            = S_COMMIT;
                        pins_d.commit_n = 1'b0;
                        tmr_load        = 1'b1;
                        tmr_val         = TW'(COM_C - 1);
                    end
                    OP_CLEAR: begin
                        st_d     = S_LEVEL_SETUP;
                        level_d  = cmd.level;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(LSU_C - 1);
                    end
                    default: ;
                endcase
            end
            S_SEL_SETUP: if (tmr_done) begin
                st_d        = S_CLK_LO;
                pins_d.sclk = 1'b0;
                tmr_load    = 1'b1;
                tmr_val     = TW'(LO_C - 1);
            end
            S_CLK_LO: if (tmr_done) begin
                st_d        = S_CLK_HI;
                pins_d.sclk = 1'b1;
                tmr_load    = 1'b1;
                tmr_val     = TW'(HI_C - 1);
            end
            S_CLK_HI: if (tmr_done) begin
                tmr_load = 1'b1;
                if (bit_q == BIT_W'(FRAME_W - 1)) begin
                    st_d           = S_LATCH;
                    pins_d.sel_n   = 1'b1;
                    pins_d.latch_n = 1'b0;
                    tmr_val        = TW'(LAT_C - 1);
                end else begin
                    st_d        = S_CLK_LO;
                    pins_d.sclk = 1'b0;
                    sh_shift    = 1'b1;
                    bit_d       = bit_q + 1'b1;
                    tmr_val     = TW'(LO_C - 1);
                end
            end
            S_LATCH: if (tmr_done) begin
                st_d           = S_LATCH_REC;
                pins_d.latch_n = 1'b1;
                tmr_load       = 1'b1;
                tmr_val        = TW'(LREC_C - 1);
            end
            S_LATCH_REC: if (tmr_done) st_d = S_IDLE;
            S_COMMIT: if (tmr_done) begin
                pins_d.commit_n = 1'b1;
                if (SETTLE_EN) begin
                    st_d     = S_SETTLE;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(SET_C - 1);
                end else begin
                    st_d = S_IDLE;
                end
            end
            S_SETTLE: if (tmr_done) st_d = S_IDLE;
            S_LEVEL_SETUP: if (tmr_done) begin
                st_d           = S_CLEAR;
                pins_d.clear_n = 1'b0;
                tmr_load       = 1'b1;
                tmr_val        = TW'(CLR_C - 1);
            end
            S_CLEAR: if (tmr_done) begin
                st_d           = S_IDLE;
                pins_d.clear_n = 1'b1;
            end
            default: st_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= S_IDLE;
            pins_q  <= PINS_IDLE;
            level_q <= LEVEL_INIT;
            bit_q   <= '0;
        end else begin
            st_q    <= st_d;
            pins_q  <= pins_d;
            level_q <= level_d;
            bit_q   <= bit_d;
        end
    end

    assign cmd_ready     = (st_q == S_IDLE);
    assign dac_sclk      = pins_q.sclk;
    assign dac_sel_n     = pins_q.sel_n;
    assign dac_mosi      = mosi;
    assign dac_latch_n   = pins_q.latch_n;
    assign dac_commit_n  = pins_q.commit_n;
    assign dac_clear_n   = pins_q.clear_n;
    assign dac_clear_mid = level_q;

    a_r3_select_rises_clock_high: assert property (@(posedge clk) disable iff (rst)
        $rose(pins_q.sel_n) |-> pins_q.sclk);
    a_r4_latch_outside_frame: assert property (@(posedge clk) disable iff (rst)
        !pins_q.latch_n |-> pins_q.sel_n);
    a_r2_data_steady_clock_high: assert property (@(posedge clk) disable iff (rst)
        (pins_q.sclk && $past(pins_q.sclk) && !pins_q.sel_n && !$past(pins_q.sel_n))
        |-> $stable(mosi));
    a_r5_commit_outside_frame: assert property (@(posedge clk) disable iff (rst)
        !pins_q.commit_n |-> (pins_q.sel_n && pins_q.latch_n && pins_q.clear_n));
    a_r7_level_held_in_clear: assert property (@(posedge clk) disable iff (rst)
        !pins_q.clear_n |-> $stable(level_q));
    a_r9_nop_keeps_ready: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready && cmd_op == 2'd3) |=> cmd_ready);
    a_r10_idle_pins: assert property (@(posedge clk) disable iff (rst)
        cmd_ready |-> (pins_q.sclk && pins_q.sel_n && pins_q.latch_n
                       && pins_q.commit_n && pins_q.clear_n));
endmodule

// File: tb/tb_serdac_writer.sv
`timescale 1ns/1ps
module tb_serdac_writer;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic        cmd_valid = 1'b0, cmd_ready, cmd_level = 1'b0;
    logic [1:0]  cmd_op = '0, cmd_chan = '0;
    logic [11:0] cmd_code = '0;
    logic sclk, sel_n, mosi, latch_n, commit_n, clear_n, clear_mid;

    serdac_writer dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_chan(cmd_chan), .cmd_code(cmd_code), .cmd_level(cmd_level),
        .dac_sclk(sclk), .dac_sel_n(sel_n), .dac_mosi(mosi), .dac_latch_n(latch_n),
        .dac_commit_n(commit_n), .dac_clear_n(clear_n), .dac_clear_mid(clear_mid)
    );

    function automatic int cy(input int ns);
        int c;
        c = (ns + 19) / 20;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    int n_tests = 0, n_fail = 0;
    int LO, HI, SSU, CSH, LD2, LAT, LREC, COM, CLR, LSU, SETC, DS;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Converter model driven only by pins, plus measurement counters.
    logic [11:0] m_in [4], m_out [4];
    logic [15:0] m_sr = '0, exp_frame = '0;
    logic p_sclk = 1, p_sel = 1, p_lat = 1, p_com = 1, p_clr = 1, p_mosi = 0;
    int sclk_run = 0, mosi_age = 0, since_rise = 0, sel_low = 0;
    int lat_run = 0, com_run = 0, clr_run = 0, nrise = 0, cyc_now = 0, acc_at = 0;
    bit mon_on = 0;

    always @(negedge clk) begin
        cyc_now++;
        since_rise++;
        sel_low++;
        if (mon_on) begin
            if (cmd_valid && cmd_ready) acc_at = cyc_now + 1;
            if (!p_sclk && sclk) begin
                chk(sclk_run >= LO, "R2 low phase", sclk_run, LO);
                if (!sel_n) begin
                    chk(mosi_age >= DS, "R2 data setup", mosi_age, DS);
                    if (nrise == 0) chk(sel_low >= SSU, "R3 select setup", sel_low, SSU);
                    m_sr = {m_sr[14:0], mosi};
                    nrise++;
                end
                since_rise = 0;
            end
            if (p_sclk && !sclk && !sel_n)
                chk(sclk_run >= HI, "R2 high phase", sclk_run, HI);
            if (mosi != p_mosi && !sel_n && !p_sel)
                chk(p_sclk && !sclk, "R2 data moves on falling edge", sclk, 0);
            if (p_sel && !sel_n) begin nrise = 0; sel_low = 0; end
            if (!p_sel && sel_n) begin
                chk(sclk == 1'b1, "R3 select rises with clock high", sclk, 1);
                chk(since_rise >= CSH, "R3 select hold", since_rise, CSH);
                chk(nrise == 16, "R1 rising edges", nrise, 16);
                chk(m_sr == exp_frame, "R1 frame", m_sr, exp_frame);
            end
            if (p_lat && !latch_n) begin
                chk(sel_n == 1'b1, "R4 latch with select high", sel_n, 1);
                chk(since_rise >= LD2, "R4 latch after last edge", since_rise, LD2);
            end
            if (!p_lat && latch_n) chk(lat_run == LAT, "R4 latch width", lat_run, LAT);
            if (!p_com && commit_n) chk(com_run == COM, "R5 commit width", com_run, COM);
            if (p_clr && !clear_n)
                chk(cyc_now - acc_at == LSU, "R7 level setup", cyc_now - acc_at, LSU);
            if (!p_clr && clear_n) chk(clr_run == CLR, "R7 clear width", clr_run, CLR);
        end
        sclk_run = (sclk != p_sclk) ? 1 : sclk_run + 1;
        mosi_age = (mosi != p_mosi) ? 1 : mosi_age + 1;
        lat_run  = (latch_n != p_lat) ? 1 : lat_run + 1;
        com_run  = (commit_n != p_com) ? 1 : com_run + 1;
        clr_run  = (clear_n != p_clr) ? 1 : clr_run + 1;
        if (!clear_n) begin
            for (int i = 0; i < 4; i++) begin
                m_in[i]  = clear_mid ? 12'h800 : 12'h000;
                m_out[i] = clear_mid ? 12'h800 : 12'h000;
            end
        end else begin
            if (!latch_n) m_in[m_sr[15:14]] = m_sr[11:0];
            if (!commit_n) for (int i = 0; i < 4; i++) m_out[i] = m_in[i];
        end
        p_sclk = sclk; p_sel = sel_n; p_lat = latch_n; p_com = commit_n;
        p_clr = clear_n; p_mosi = mosi;
    end

    logic [11:0] e_in [4], e_out [4];

    task automatic send(input logic [1:0] op, input logic [1:0] ch,
                        input logic [11:0] code, input logic lvl, input string tag);
        int n, exp_busy;
        exp_frame = {ch, 2'b00, code};
        @(posedge clk); #3;
        cmd_valid = 1'b1; cmd_op = op; cmd_chan = ch; cmd_code = code; cmd_level = lvl;
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        @(posedge clk); #3;
        cmd_valid = 1'b0;
        n = 0;
        @(negedge clk);
        while (!cmd_ready) begin n++; @(negedge clk); end
        #1;
        case (op)
            2'd0: begin exp_busy = SSU + 16 * (LO + HI) + LAT + LREC; e_in[ch] = code; end
            2'd1: begin exp_busy = COM + SETC; for (int i = 0; i < 4; i++) e_out[i] = e_in[i]; end
            2'd2: begin
                exp_busy = LSU + CLR;
                for (int i = 0; i < 4; i++) begin
                    e_in[i] = lvl ? 12'h800 : 12'h000;
                    e_out[i] = e_in[i];
                end
            end
            default: exp_busy = 0;
        endcase
        chk(n == exp_busy, (op == 2'd1) ? "R6 update busy" : (op == 2'd3) ? "R9 no-op busy" : "R8 busy", n, exp_busy);
        for (int i = 0; i < 4; i++) begin
            chk(m_in[i] == e_in[i], {tag, " channel register"}, m_in[i], e_in[i]);
            chk(m_out[i] == e_out[i], {tag, " output"}, m_out[i], e_out[i]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int r;
        logic [1:0] op;
        LO = mx(cy(50), cy(25)); HI = mx(mx(cy(30), cy(20)), mx(cy(15), cy(15)));
        SSU = cy(55); CSH = cy(15); LD2 = cy(15); LAT = cy(45); LREC = cy(40);
        COM = cy(45); CLR = cy(70); LSU = cy(25); SETC = cy(10000); DS = cy(25);
        void'($urandom(32'd7331));
        repeat (3) @(posedge clk);
        #3 rst = 1'b0;
        @(negedge clk);
        // R10: idle levels after reset
        chk(cmd_ready && sclk && sel_n && latch_n && commit_n && clear_n,
            "R10 reset state", {cmd_ready, sclk, sel_n, latch_n, commit_n, clear_n}, 6'h3f);
        mon_on = 1'b1;
        send(2'd2, 2'd0, 12'h000, 1'b1, "R7 clear mid");
        send(2'd0, 2'd0, 12'h000, 1'b0, "R1 write zero");
        send(2'd0, 2'd1, 12'hFFF, 1'b0, "R1 write full");
        send(2'd0, 2'd2, 12'hA5A, 1'b0, "R4 write pattern");
        send(2'd0, 2'd3, 12'h5A5, 1'b0, "R11 no commit yet");
        send(2'd1, 2'd0, 12'h000, 1'b0, "R5 update all");
        send(2'd0, 2'd3, 12'h001, 1'b0, "R11 buffered write");
        send(2'd3, 2'd2, 12'hFFF, 1'b1, "R9 no-op");
        @(negedge clk);
        chk(cmd_ready && sclk && sel_n && latch_n && commit_n && clear_n,
            "R9 pins idle after no-op", {cmd_ready, sclk, sel_n, latch_n, commit_n, clear_n}, 6'h3f);
        send(2'd2, 2'd0, 12'h000, 1'b0, "R7 clear zero");
        for (int k = 0; k < 40; k++) begin
            r = int'($urandom % 10);
            op = (r < 6) ? 2'd0 : (r < 8) ? 2'd1 : (r < 9) ? 2'd2 : 2'd3;
            send(op, 2'($urandom), 12'($urandom), 1'($urandom), "R1 random");
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule